// File: doc/BRIEF.md
# Windowed 1-0-1 Serial Pattern Tally

This block watches a serial data line, one bit per clock, and counts how often the three-bit sequence 1, 0, 1 shows up inside a fixed observation window. When a window ends, the tally for that window is copied into an output register, a one-cycle valid flag is raised, and counting starts again from zero for the next window. Overlapping occurrences count separately. The window timer restarts on its own, so windows follow one another back to back.

The block has four parts. A reset stretcher keeps an internal reset active for a few clocks after the external reset is released. A sequence detector state machine pulses when the pattern completes. A saturating counter adds up those pulses. A capture register holds the final tally for the whole of the following window. The detector has three states. DET_IDLE means no useful history, and DET_ONE means the last bit was a 1. DET_ONE_ZERO means the last two bits were 1 then 0. The transitions are:
- "start" goes from DET_IDLE to DET_ONE on a 1.
- "stay-idle" keeps DET_IDLE on a 0.
- "repeat-one" keeps DET_ONE on a 1.
- "gap" goes from DET_ONE to DET_ONE_ZERO on a 0.
- "complete" goes from DET_ONE_ZERO to DET_ONE on a 1 and raises the hit pulse.
- "break" goes from DET_ONE_ZERO to DET_IDLE on a 0.
- "flush" sends every state to DET_IDLE while the internal reset is active.

The detector is not cleared at window boundaries. A sequence that straddles a boundary is credited to the window in which its final 1 arrives.

Top module: `serial_101_tally`

## Requirements
- R1: While the internal reset is active, `count_o` reads 0 and `valid_o` reads 0.
- R2: The internal reset stays active for RST_HOLD (4) rising edges after `rst_i` is released. The first window then spans the next WIN_LEN edges, so the first `valid_o` follows the edge numbered RST_HOLD+WIN_LEN after release.
- R3: A hit is counted for every edge at which `din_i` is 1 and the two previous sampled bits were 1 then 0. Overlaps count, so 1,0,1,0,1 gives 2. A sequence spanning a window boundary counts in the window of its last bit.
- R4: Windows are WIN_LEN (default 200) edges long and repeat without a gap. `valid_o` is high for exactly one cycle after the last edge of each window.
- R5: At the end of a window, `count_o` takes that window's tally, including a hit on its last edge. It then holds that value until the next window ends.
- R6: The running count clears at each window end, so each window's tally starts from 0.
- R7: The tally saturates at 255 (all ones in CNT_W bits) and never wraps.
- R8: An external reset during operation returns the detector to DET_IDLE. A partial 1,0 seen before the reset cannot complete a hit after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | External reset, active high, asserted asynchronously |
| din_i | input | 1 | Serial data bit, sampled every rising edge |
| count_o | output | CNT_W (8) | Tally captured at the end of the latest window |
| valid_o | output | 1 | One-cycle pulse marking a fresh `count_o` |

## Verification
Two things can coincide on a single edge: the detector's hit, and the window close that captures and clears the counter. The bench provokes this by placing a 1,0,1 so its final 1 lands on the last edge of a window. It also places a 1,0 at the end of one window and a 1 at the start of the next. A behavioural model, built from bit history and integer counters, predicts the captured value on every clock. The directed windows also check the exact tallies, 1 for the closing-edge hit and 0 then 1 for the straddling sequence.

// File: rtl/s101_pkg.sv
`timescale 1ns/1ps
package s101_pkg;
    typedef enum logic [1:0] {
        DET_IDLE     = 2'd0,
        DET_ONE      = 2'd1,
        DET_ONE_ZERO = 2'd2
    } det_state_e;
endpackage

// File: rtl/s101_rst_stretch.sv
`timescale 1ns/1ps
module s101_rst_stretch #(
    parameter int HOLD = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic srst_o
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            hold_q <= '0;
        end else if (hold_q != HOLD_END) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    assign srst_o = rst_i || (hold_q != HOLD_END);

    // R2
    release_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(srst_o) |-> $past(srst_o, 2));
endmodule

// File: rtl/s101_detect.sv
`timescale 1ns/1ps
module s101_detect
    import s101_pkg::*;
(
    input  logic clk_i,
    input  logic srst_i,
    input  logic din_i,
    output logic hit_o
);
    det_state_e state_q;
    det_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= DET_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_IDLE:     state_d = din_i ? DET_ONE : DET_IDLE;
            DET_ONE:      state_d = din_i ? DET_ONE : DET_ONE_ZERO;
            DET_ONE_ZERO: state_d = din_i ? DET_ONE : DET_IDLE;
            default:      state_d = DET_IDLE;
        endcase
    end

    always_comb begin
        hit_o = (state_q == DET_ONE_ZERO) && din_i;
    end

    // R3
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        hit_o |=> !hit_o);
endmodule

// File: rtl/s101_window.sv
`timescale 1ns/1ps
module s101_window #(
    parameter int WIN_LEN = 200
) (
    input  logic clk_i,
    input  logic srst_i,
    output logic last_o
);
    localparam int TW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [TW-1:0] LAST_IDX = TW'(WIN_LEN - 1);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            tick_q <= '0;
        end else if (tick_q == LAST_IDX) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign last_o = (tick_q == LAST_IDX);

    // R4
    window_gap_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        last_o |=> !last_o);
endmodule

// File: rtl/s101_tally.sv
`timescale 1ns/1ps
module s101_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic             hit_i,
    input  logic             last_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;

    always_comb begin
        run_inc = (hit_i && (run_q != CNT_MAX)) ? run_q + 1'b1 : run_q;
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            run_q   <= '0;
            count_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_i;
            if (last_i) begin
                count_o <= run_inc;
                run_q   <= '0;
            end else begin
                run_q   <= run_inc;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        srst_i |=> (count_o == '0) && !valid_o);
    // R7
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        !last_i |=> run_q >= $past(run_q));
    // R6
    clear_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        valid_o |-> run_q == '0);
    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        !valid_o |-> $stable(count_o));
    // R4
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        valid_o |=> !valid_o);
endmodule

// File: rtl/serial_101_tally.sv
`timescale 1ns/1ps
module serial_101_tally #(
    parameter int WIN_LEN  = 200,
    parameter int CNT_W    = 8,
    parameter int RST_HOLD = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             din_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o
);
    logic srst;
    logic hit;
    logic last;

    s101_rst_stretch #(.HOLD(RST_HOLD)) u_rst (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .srst_o (srst)
    );

    s101_detect u_detect (
        .clk_i  (clk_i),
        .srst_i (srst),
        .din_i  (din_i),
        .hit_o  (hit)
    );

    s101_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk_i  (clk_i),
        .srst_i (srst),
        .last_o (last)
    );

    s101_tally #(.CNT_W(CNT_W)) u_tally (
        .clk_i   (clk_i),
        .srst_i  (srst),
        .hit_i   (hit),
        .last_i  (last),
        .count_o (count_o),
        .valid_o (valid_o)
    );
endmodule

// File: tb/serial_101_tally_bench.sv
`timescale 1ns/1ps
module serial_101_tally_bench;
    localparam int WIN  = 600;
    localparam int HOLD = 4;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       din_i = 1'b0;
    logic [7:0] count_o;
    logic       valid_o;

    serial_101_tally #(.WIN_LEN(WIN), .CNT_W(8), .RST_HOLD(HOLD)) u_serial_101_tally (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (din_i),
        .count_o (count_o),
        .valid_o (valid_o)
    );

    always #2.5 clk_i = ~clk_i;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int m_hold = 0, m_tmr = 0, m_cnt = 0, m_len = 0, m_nc = 0;
    int since_rel = 0;
    bit p1 = 1'b0, p2 = 1'b0, m_hit = 1'b0;
    bit last_was_rst = 1'b0;
    int e_count = 0;
    bit e_valid = 1'b0;

    always @(posedge clk_i) begin
        if (rst_i) begin
            since_rel = 0;
            m_hold = HOLD;
        end else begin
            since_rel++;
        end
        if (rst_i || m_hold > 0) begin
            if (!rst_i) m_hold--;
            m_tmr = 0; m_cnt = 0; m_len = 0;
            e_count = 0; e_valid = 1'b0;
            last_was_rst = 1'b1;
        end else begin
            last_was_rst = 1'b0;
            m_hit = (m_len >= 2) && p2 && !p1 && din_i;
            p2 = p1;
            p1 = din_i;
            if (m_len < 2) m_len++;
            m_nc = m_cnt + (m_hit ? 1 : 0);
            if (m_nc > 255) m_nc = 255;
            if (m_tmr == WIN - 1) begin
                e_count = m_nc; e_valid = 1'b1; m_cnt = 0; m_tmr = 0;
            end else begin
                m_cnt = m_nc; e_valid = 1'b0; m_tmr++;
            end
        end
    end

    task automatic check(string tag, int got, int exp, string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int exp_of(int idx);
        case (idx)
            0: return 0;     // R4 quiet window
            1: return 2;     // R3 overlap 1,0,1,0,1
            2: return 1;     // R5 hit on closing edge
            3: return 0;     // R3 first half of straddle
            4: return 1;     // R3 straddle completes here
            5: return 255;   // R7 saturation
            6: return 0;     // R6 cleared after saturation
            9: return 0;     // R6
            10: return 0;    // R8 partial sequence flushed by reset
            default: return -1;
        endcase
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            0: return "R4";
            1, 3, 4: return "R3";
            2, 7, 8: return "R5";
            5: return "R7";
            6, 9: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic bit gen_bit(int idx, int t);
        case (idx)
            1: return (t < 5) && (t % 2 == 0);
            2: return (t == WIN - 3) || (t == WIN - 1);
            3: return t == WIN - 2;
            4: return t == 0;
            5: return t % 2 == 0;
            7, 8: return 1'($urandom_range(0, 1));
            default: return 1'b0;
        endcase
    endfunction

    int    win_idx = 0;
    int    rst_left = 3;
    bit    want_r2 = 1'b1;
    bit    probe_fired = 1'b0;
    string cur_tag = "R4";

    always @(negedge clk_i) begin
        if (!finished) begin
            check(cur_tag, int'(count_o), e_count, "count_o per cycle");
            check(cur_tag, int'(valid_o), int'(e_valid), "valid_o per cycle");
            if (last_was_rst) begin
                check("R1", int'(count_o), 0, "count_o in reset");
                check("R1", int'(valid_o), 0, "valid_o in reset");
            end
            if (valid_o && want_r2) begin
                check("R2", since_rel, HOLD + WIN, "edges from release to first valid_o");
                want_r2 = 1'b0;
            end
            if (e_valid) begin
                if (exp_of(win_idx) >= 0)
                    check(tag_of(win_idx), int'(count_o), exp_of(win_idx), "window tally");
                win_idx++;
                cur_tag = tag_of(win_idx);
                if (win_idx == 11) finished = 1'b1;
            end
            if (rst_left > 0) begin
                rst_left--;
                if (rst_left == 0) rst_i = 1'b0;
            end
            if (win_idx == 10) begin
                if (!probe_fired && m_tmr == 102) begin
                    rst_i = 1'b1; rst_left = 2; probe_fired = 1'b1; want_r2 = 1'b1;
                end
                if (rst_i || m_hold > 0)   din_i = 1'b1;
                else if (!probe_fired)     din_i = (m_tmr == 100);
                else                       din_i = (m_tmr == 1);
            end else begin
                din_i = gen_bit(win_idx, m_tmr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual window %0d expected 11", win_idx);
            finished = 1'b1;
        end
    end

    initial begin
        wait (finished);
        #1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule